// File: doc/BRIEF.md
# Neighbor-Coincidence Array Trigger

This block makes one telescope's array-level trigger decision. The other telescopes of its sub-array send trigger reports. Each report carries a telescope id and a time stamp. The block keeps one report per neighbor. Before storing a report, it subtracts that neighbor's signed propagation delay, so that all stored stamps sit on the local time base.

A local trigger is not judged at once. The block first waits a fixed latency, so that late neighbor reports can still arrive. It then counts the enabled neighbors whose corrected stamp lies within a programmable window of the local stamp. If that count reaches a programmable threshold, the block emits a one-cycle decision. The decision carries a participation map and the local stamp.

A local trigger that fails the test can still pass through on a divide-by-M prescaler, flagged as a pass-through event. This keeps a thin stream of calibration events. A test mode replaces the live report input with a separate injection port, so the trigger path can be exercised in place.

Top module: `at_array_trig`

## Requirements
- R1: While reset is held and in the cycle after it, `trg_vld`, `trg_pass`, `trg_map` and `trg_ts` are all zero.
- R2: A report sampled with id 1..8 replaces that neighbor's entry with the stamp minus the neighbor's signed 16-bit delay. The delay for neighbor i is `cfg_dly[16*(i-1) +: 16]`. Reports with id 0 or id 9..15 change nothing.
- R3: An entry takes part in evaluation only if it was written no more than 2*LAT clock edges before the evaluating edge. Otherwise it counts as absent.
- R4: A local trigger accepted at clock edge k produces its result at edge k+LAT+1. When there is a result, `trg_vld` is high for exactly one cycle. A local trigger that arrives while an earlier one is still waiting is ignored.
- R5: A neighbor is coincident when the absolute difference between its corrected stamp and the local stamp is less than or equal to `cfg_win`.
- R6: The block fires a normal decision (`trg_pass`=0) when the number of coincident enabled neighbors is at least `cfg_thr`.
- R7: On every decision, `trg_map` bit 0 is 1 (the local telescope). Bit i (1..8) is 1 exactly when neighbor i is enabled and coincident. `trg_ts` equals the local stamp.
- R8: A neighbor whose bit i-1 of `cfg_mask` is 0 is excluded. It counts neither toward the threshold nor in the map.
- R9: A local trigger that fails the threshold advances a prescale counter when `cfg_ps`=M is non-zero. Every M-th such failure emits a decision with `trg_pass`=1. When M=0, failed triggers emit nothing and leave the counter unchanged.
- R10: While `tst_en` is 1, reports come only from the `tst_*` port and live `rpt_*` reports are ignored. While `tst_en` is 0, the reverse holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_vld | input | 1 | Live neighbor report strobe |
| rpt_id | input | 4 | Live report telescope id |
| rpt_ts | input | 24 | Live report time stamp |
| tst_en | input | 1 | Select the injection port instead of the live port |
| tst_vld | input | 1 | Injected report strobe |
| tst_id | input | 4 | Injected report telescope id |
| tst_ts | input | 24 | Injected report time stamp |
| loc_vld | input | 1 | Local trigger strobe |
| loc_ts | input | 24 | Local trigger time stamp |
| cfg_dly | input | 128 | Eight signed 16-bit delay corrections, neighbor 1 in the low bits |
| cfg_win | input | 12 | Coincidence half-window in ticks |
| cfg_thr | input | 4 | Neighbor count threshold |
| cfg_mask | input | 8 | Neighbor enable, bit i-1 for neighbor i |
| cfg_ps | input | 16 | Prescale divisor M, 0 disables pass-through |
| trg_vld | output | 1 | One-cycle decision pulse |
| trg_pass | output | 1 | Decision is a prescaled pass-through |
| trg_map | output | 9 | Participation map, bit 0 local |
| trg_ts | output | 24 | Local stamp of the decision |

## Verification
A decision is due exactly LAT+1 edges after the edge that accepted its local trigger. A report written at edge r is still usable by an evaluation at edge e when e-1-r is below 2*LAT. The bench's behavioural model applies both rules with integer counters. The model is updated on the rising edge from the same inputs the design samples. Its expected outputs are compared with the design at every falling edge, so each result is checked in the single cycle in which it must appear and absent pulses are caught as well.

// File: rtl/at_pkg.sv
package at_pkg;
    localparam int AT_NTEL  = 9;
    localparam int AT_NNB   = AT_NTEL - 1;
    localparam int AT_ID_W  = 4;
    localparam int AT_TS_W  = 24;
    localparam int AT_DLY_W = 16;
    localparam int AT_WIN_W = 12;
    localparam int AT_THR_W = 4;
    localparam int AT_PS_W  = 16;
    localparam int AT_CNT_W = $clog2(AT_NNB + 1);

    typedef struct packed {
        logic                 vld;
        logic [AT_ID_W-1:0]   id;
        logic [AT_TS_W-1:0]   ts;
    } at_rpt_t;

    typedef struct packed {
        logic                 vld;
        logic                 pass;
        logic [AT_NTEL-1:0]   map;
        logic [AT_TS_W-1:0]   ts;
    } at_dec_t;

    function automatic logic [AT_TS_W+2:0] at_absdiff(
        input logic signed [AT_TS_W+1:0] a,
        input logic signed [AT_TS_W+1:0] b);
        logic signed [AT_TS_W+2:0] d;
        d = {a[AT_TS_W+1], a} - {b[AT_TS_W+1], b};
        return d[AT_TS_W+2] ? -d : d;
    endfunction
endpackage

// File: rtl/at_nbr_buf.sv
module at_nbr_buf
    import at_pkg::*;
#(
    parameter int KEEP = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [AT_TS_W-1:0]   ts,
    input  logic [AT_DLY_W-1:0]  dly,
    input  logic                 en,
    input  logic [AT_TS_W-1:0]   lts,
    input  logic [AT_WIN_W-1:0]  win,
    output logic                 hit
);
    localparam int AGE_W = $clog2(KEEP + 1);

    logic signed [AT_TS_W+1:0] corr;
    logic [AGE_W-1:0]          age;
    logic [AT_TS_W+2:0]        mag;

    always_ff @(posedge clk) begin
        if (rst) begin
            corr <= '0;
            age  <= AGE_W'(KEEP);
        end else if (wr) begin
            corr <= $signed({2'b00, ts}) - {{(AT_TS_W+2-AT_DLY_W){dly[AT_DLY_W-1]}}, dly};
            age  <= '0;
        end else if (age < AGE_W'(KEEP)) begin
            age  <= age + 1'b1;
        end
    end

    always_comb begin
        mag = at_absdiff(corr, $signed({2'b00, lts}));
        hit = en && (age < AGE_W'(KEEP)) &&
              (mag <= {{(AT_TS_W+3-AT_WIN_W){1'b0}}, win});
    end

    AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(corr)) else $error("stamp changed without a write"); // R2
endmodule

// File: rtl/at_prescale.sv
module at_prescale
    import at_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fail,
    input  logic [AT_PS_W-1:0]  m,
    output logic                pass
);
    logic [AT_PS_W-1:0] cnt;

    always_comb pass = fail && (m != '0) && (cnt >= m - 1'b1);

    always_ff @(posedge clk) begin
        if (rst)                    cnt <= '0;
        else if (pass)              cnt <= '0;
        else if (fail && m != '0)   cnt <= cnt + 1'b1;
    end

    AST_PS_OFF: assert property (@(posedge clk) disable iff (rst)
        (m == '0) |-> !pass) else $error("pass-through while disabled"); // R9
endmodule

// File: rtl/at_array_trig.sv
module at_array_trig
    import at_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rpt_vld,
    input  logic [AT_ID_W-1:0]          rpt_id,
    input  logic [AT_TS_W-1:0]          rpt_ts,
    input  logic                        tst_en,
    input  logic                        tst_vld,
    input  logic [AT_ID_W-1:0]          tst_id,
    input  logic [AT_TS_W-1:0]          tst_ts,
    input  logic                        loc_vld,
    input  logic [AT_TS_W-1:0]          loc_ts,
    input  logic [AT_NNB*AT_DLY_W-1:0]  cfg_dly,
    input  logic [AT_WIN_W-1:0]         cfg_win,
    input  logic [AT_THR_W-1:0]         cfg_thr,
    input  logic [AT_NNB-1:0]           cfg_mask,
    input  logic [AT_PS_W-1:0]          cfg_ps,
    output logic                        trg_vld,
    output logic                        trg_pass,
    output logic [AT_NTEL-1:0]          trg_map,
    output logic [AT_TS_W-1:0]          trg_ts
);
    localparam int KEEP  = 2 * LAT;
    localparam int LCT_W = $clog2(LAT + 1);

    at_rpt_t             src;
    logic [AT_NNB-1:0]   hits;
    logic [AT_CNT_W-1:0] nhit;
    logic                pend, fire_now, meet, ps_pass;
    logic [LCT_W-1:0]    lcnt;
    logic [AT_TS_W-1:0]  lts;
    at_dec_t             dec;

    always_comb begin
        src = tst_en ? '{vld: tst_vld, id: tst_id, ts: tst_ts}
                     : '{vld: rpt_vld, id: rpt_id, ts: rpt_ts};
    end

    for (genvar i = 0; i < AT_NNB; i++) begin : g_nb
        at_nbr_buf #(.KEEP(KEEP)) u_buf (
            .clk (clk),
            .rst (rst),
            .wr  (src.vld && (src.id == AT_ID_W'(i + 1))),
            .ts  (src.ts),
            .dly (cfg_dly[i*AT_DLY_W +: AT_DLY_W]),
            .en  (cfg_mask[i]),
            .lts (lts),
            .win (cfg_win),
            .hit (hits[i])
        );
    end

    always_comb begin
        nhit     = AT_CNT_W'($countones(hits));
        fire_now = pend && (lcnt == '0);
        meet     = {{(AT_THR_W > AT_CNT_W ? 0 : AT_CNT_W-AT_THR_W){1'b0}}, nhit} >= cfg_thr;
    end

    at_prescale u_ps (
        .clk  (clk),
        .rst  (rst),
        .fail (fire_now && !meet),
        .m    (cfg_ps),
        .pass (ps_pass)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            lcnt <= '0;
            lts  <= '0;
            dec  <= '0;
        end else begin
            dec <= '0;
            if (fire_now) begin
                pend <= 1'b0;
                if (meet || ps_pass)
                    dec <= '{vld: 1'b1, pass: !meet, map: {hits, 1'b1}, ts: lts};
            end else if (pend) begin
                lcnt <= lcnt - 1'b1;
            end else if (loc_vld) begin
                pend <= 1'b1;
                lcnt <= LCT_W'(LAT);
                lts  <= loc_ts;
            end
        end
    end

    assign trg_vld  = dec.vld;
    assign trg_pass = dec.pass;
    assign trg_map  = dec.map;
    assign trg_ts   = dec.ts;

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        trg_vld |=> !trg_vld) else $error("decision wider than one cycle"); // R4
    AST_LOCAL_BIT: assert property (@(posedge clk) disable iff (rst)
        trg_vld |-> trg_map[0]) else $error("local bit missing"); // R7
    AST_MASKED_OUT: assert property (@(posedge clk) disable iff (rst)
        trg_vld |-> ((trg_map[AT_NTEL-1:1] & ~$past(cfg_mask)) == '0)) else $error("masked neighbor in map"); // R8
    AST_THR_MET: assert property (@(posedge clk) disable iff (rst)
        (trg_vld && !trg_pass) |-> ($countones(trg_map[AT_NTEL-1:1]) >= int'($past(cfg_thr)))) else $error("fired below threshold"); // R6
    AST_PASS_COND: assert property (@(posedge clk) disable iff (rst)
        (trg_vld && trg_pass) |-> (($countones(trg_map[AT_NTEL-1:1]) < int'($past(cfg_thr))) && ($past(cfg_ps) != '0))) else $error("bad pass-through"); // R9
endmodule

// File: tb/sim_at_array_trig.sv
module sim_at_array_trig;
    import at_pkg::*;

    localparam int LAT  = 4;
    localparam int KEEP = 2 * LAT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rpt_vld = 0, tst_en = 0, tst_vld = 0, loc_vld = 0;
    logic [3:0] rpt_id = 0, tst_id = 0;
    logic [AT_TS_W-1:0] rpt_ts = 0, tst_ts = 0, loc_ts = 0;
    logic [AT_NNB*AT_DLY_W-1:0] cfg_dly = 0;
    logic [AT_WIN_W-1:0] cfg_win = 0;
    logic [AT_THR_W-1:0] cfg_thr = 0;
    logic [AT_NNB-1:0] cfg_mask = 0;
    logic [AT_PS_W-1:0] cfg_ps = 0;
    logic trg_vld, trg_pass;
    logic [AT_NTEL-1:0] trg_map;
    logic [AT_TS_W-1:0] trg_ts;

    int total = 0, bad = 0;
    int tick = 0;
    bit finished = 0;
    string scen = "reset R1";

    always #5 clk = ~clk;

    at_array_trig #(.LAT(LAT)) u0 (
        .clk(clk), .rst(rst),
        .rpt_vld(rpt_vld), .rpt_id(rpt_id), .rpt_ts(rpt_ts),
        .tst_en(tst_en), .tst_vld(tst_vld), .tst_id(tst_id), .tst_ts(tst_ts),
        .loc_vld(loc_vld), .loc_ts(loc_ts),
        .cfg_dly(cfg_dly), .cfg_win(cfg_win), .cfg_thr(cfg_thr),
        .cfg_mask(cfg_mask), .cfg_ps(cfg_ps),
        .trg_vld(trg_vld), .trg_pass(trg_pass), .trg_map(trg_map), .trg_ts(trg_ts)
    );

    // behavioural reference model
    longint m_st [1:8];
    int     m_age [1:8];
    bit     m_pend;
    int     m_cnt;
    longint m_lts;
    int     m_pc;
    bit     e_vld, e_pass;
    logic [8:0] e_map;
    longint e_ts;

    function automatic longint dly_of(int i);
        return longint'($signed(cfg_dly[(i-1)*16 +: 16]));
    endfunction

    always @(posedge clk) begin
        tick++;
        if (rst) begin
            for (int i = 1; i <= 8; i++) begin m_st[i] = 0; m_age[i] = KEEP; end
            m_pend = 0; m_cnt = 0; m_lts = 0; m_pc = 0;
            e_vld = 0; e_pass = 0; e_map = 0; e_ts = 0;
        end else begin
            bit sv; int sid; longint sts;
            e_vld = 0; e_pass = 0; e_map = 0; e_ts = 0;
            if (m_pend && m_cnt == 0) begin
                int n; logic [8:0] mp;
                n = 0; mp = 9'd1;
                for (int i = 1; i <= 8; i++) begin
                    longint d;
                    d = m_st[i] - m_lts;
                    if (d < 0) d = -d;
                    if (cfg_mask[i-1] && m_age[i] < KEEP && d <= longint'(cfg_win)) begin
                        n++; mp[i] = 1'b1;
                    end
                end
                if (n >= int'(cfg_thr)) begin
                    e_vld = 1; e_map = mp; e_ts = m_lts;
                end else if (cfg_ps != 0) begin
                    if (m_pc >= int'(cfg_ps) - 1) begin
                        e_vld = 1; e_pass = 1; e_map = mp; e_ts = m_lts; m_pc = 0;
                    end else m_pc++;
                end
                m_pend = 0;
            end else if (m_pend) begin
                m_cnt--;
            end else if (loc_vld) begin
                m_pend = 1; m_cnt = LAT; m_lts = longint'(loc_ts);
            end
            sv  = tst_en ? tst_vld : rpt_vld;
            sid = tst_en ? int'(tst_id) : int'(rpt_id);
            sts = tst_en ? longint'(tst_ts) : longint'(rpt_ts);
            for (int i = 1; i <= 8; i++) begin
                if (sv && sid == i) begin m_st[i] = sts - dly_of(i); m_age[i] = 0; end
                else if (m_age[i] < KEEP) m_age[i]++;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            total++;
            if (trg_vld !== e_vld) begin
                bad++;
                $display("FAIL R4 [%s] trg_vld actual=%0b expected=%0b t=%0d", scen, trg_vld, e_vld, tick);
            end
            if (e_vld && trg_vld === 1'b1) begin
                total += 3;
                if (trg_pass !== e_pass) begin
                    bad++;
                    $display("FAIL R6/R9 [%s] trg_pass actual=%0b expected=%0b", scen, trg_pass, e_pass);
                end
                if (trg_map !== e_map) begin
                    bad++;
                    $display("FAIL R7 [%s] trg_map actual=%b expected=%b", scen, trg_map, e_map);
                end
                if (longint'(trg_ts) != e_ts) begin
                    bad++;
                    $display("FAIL R7 [%s] trg_ts actual=%0d expected=%0d", scen, trg_ts, e_ts);
                end
            end
        end
    end

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic rep(input int id, input longint ts, input bit tst);
        @(negedge clk);
        if (tst) begin tst_vld = 1; tst_id = 4'(id); tst_ts = AT_TS_W'(ts); end
        else     begin rpt_vld = 1; rpt_id = 4'(id); rpt_ts = AT_TS_W'(ts); end
        @(negedge clk);
        rpt_vld = 0; tst_vld = 0;
    endtask

    task automatic loc(input longint ts);
        @(negedge clk); loc_vld = 1; loc_ts = AT_TS_W'(ts);
        @(negedge clk); loc_vld = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: run hung, actual=running expected=done");
            finished = 1;
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) cfg_dly[i*16 +: 16] = 16'(100 * (i + 1) - 350);
        cfg_win = 12'd20; cfg_thr = 4'd2; cfg_mask = 8'hFF; cfg_ps = 16'd0;
        repeat (3) @(negedge clk);
        // R1: outputs zero under reset
        total++;
        if ({trg_vld, trg_pass, trg_map, trg_ts} !== '0) begin
            bad++; $display("FAIL R1 reset outputs actual=%h expected=0", {trg_vld, trg_pass, trg_map, trg_ts});
        end
        rst = 0;
        @(negedge clk);
        total++;
        if (trg_vld !== 1'b0) begin bad++; $display("FAIL R1 after reset trg_vld actual=%0b expected=0", trg_vld); end

        // R2 R5: corrected stamps, window edge (diff 20 hits, 21 misses)
        scen = "R2 R5 window edge";
        cfg_thr = 4'd1;
        rep(1, 1000 + (100 - 350) + 20, 0);
        rep(2, 1000 + (200 - 350) - 21, 0);
        rep(3, 1000 + (300 - 350) - 20, 0);
        loc(1000); idle(LAT + 4);

        // R2: invalid ids change nothing
        scen = "R2 bad id";
        rep(0, 5000, 0); rep(9, 5000, 0); rep(15, 5000, 0);
        loc(5000); idle(LAT + 4);

        // R6: threshold met / not met
        scen = "R6 threshold";
        cfg_thr = 4'd3;
        rep(4, 2000 + 50, 0); rep(5, 2000 + 150, 0);
        loc(2000); idle(LAT + 4);
        rep(6, 3000 + 250, 0); rep(7, 3000 + 350, 0); rep(8, 3000 + 450, 0);
        loc(3000); idle(LAT + 4);

        // R3: stale entries expire; late reports still counted
        scen = "R3 lifetime";
        cfg_thr = 4'd1;
        rep(1, 4000 - 250, 0); idle(2 * KEEP);
        loc(4000); idle(LAT + 4);
        loc(4100); idle(LAT - 2); rep(2, 4100 - 150, 0); idle(6);

        // R4: second local while pending is ignored
        scen = "R4 busy";
        rep(3, 4500 - 50, 0);
        loc(4500); loc(4501); idle(LAT + 6);

        // R8: masked neighbors excluded
        scen = "R8 mask";
        cfg_mask = 8'b1111_1010;
        cfg_thr = 4'd2;
        rep(1, 6000 - 250, 0); rep(3, 6000 - 50, 0); rep(2, 6000 - 150, 0);
        loc(6000); idle(LAT + 4);
        cfg_mask = 8'hFF;

        // R9: prescale every 3rd failure, then M=0
        scen = "R9 prescale";
        cfg_thr = 4'd8; cfg_ps = 16'd3;
        for (int k = 0; k < 7; k++) begin loc(7000 + k); idle(LAT + 2); end
        cfg_ps = 16'd0;
        for (int k = 0; k < 3; k++) begin loc(7100 + k); idle(LAT + 2); end

        // R10: test port replaces live port
        scen = "R10 test inject";
        cfg_thr = 4'd1; tst_en = 1;
        rep(1, 8000 - 250, 0);
        loc(8000); idle(LAT + 4);
        rep(2, 8100 - 150, 1);
        loc(8100); idle(LAT + 4);
        tst_en = 0;
        rep(3, 8200 - 50, 1);
        loc(8200); idle(LAT + 4);

        // mixed random traffic, all requirements via the model
        scen = "R2 R3 R5 R8 R10 random";
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if (c % 300 == 0) begin
                cfg_win  = 12'($urandom_range(5, 40));
                cfg_thr  = 4'($urandom_range(0, 5));
                cfg_mask = 8'($urandom);
                cfg_ps   = 16'($urandom_range(0, 4));
                tst_en   = ($urandom_range(0, 3) == 0);
            end
            rpt_vld = ($urandom_range(0, 1) == 1);
            rpt_id  = 4'($urandom_range(0, 10));
            rpt_ts  = AT_TS_W'(10000 + c + 100 * int'(rpt_id) - 350 + $urandom_range(0, 60) - 30);
            tst_vld = ($urandom_range(0, 2) == 0);
            tst_id  = 4'($urandom_range(1, 8));
            tst_ts  = AT_TS_W'(10000 + c + 100 * int'(tst_id) - 350 + $urandom_range(0, 40) - 20);
            loc_vld = ($urandom_range(0, 7) == 0);
            loc_ts  = AT_TS_W'(10000 + c);
        end
        @(negedge clk);
        rpt_vld = 0; tst_vld = 0; loc_vld = 0;
        idle(3 * LAT);

        finished = 1;
        summary();
        $finish;
    end
endmodule